// File: doc/BRIEF.md
# Transmit Line Error Injector

This block sits on the outgoing bipolar line stream, after the framing, CRC and line coding stages. Software or test logic pulses a request for a single error of one of three kinds: a line code violation, an inverted framing bit, or an inverted CRC bit. Each request is held in a pending flag until the stream reaches a bit where the error can be placed. The error is then applied once and the flag clears itself. Writing zero does nothing, and any mix of the three kinds can be pending at the same time.

The datapath is combinational from the input rails to the output rails, so it adds no latency. Registered state holds the three pending flags, the polarity of the last mark sent and whether the previous bit was a mark. In T1 mode the block rebuilds the alternating-mark polarity itself, so an injected violation counts as exactly one fault at the far end. In E1 mode the upstream HDB3 polarity passes through unchanged. A violation there flips the polarity of one mark, which gives two violations of the same polarity in a row. A receiver counts that pair as a single line code violation.

Top module: `tx_err_inject`

## Requirements
- R1: A one on `req_lcv`, `req_frm` or `req_crc` sets the matching pending output on the next clock edge, unless the error is applied in that same cycle.
- R2: While a request input is zero, the matching pending flag keeps its value until its error is applied. A position strobe that arrives with no request pending leaves the bit unchanged.
- R3: Two or three error kinds can be pending at once. Each one is applied and cleared on its own.
- R4: A pending line code violation stays set through every bit it cannot use, and clears on the edge that ends the bit it was applied to.
- R5: In T1 mode (`mode_e1`=0), a violation is applied only to a mark whose previous output bit was also a mark. That mark repeats the polarity of the previous mark, and later marks alternate starting from it.
- R6: In E1 mode (`mode_e1`=1), a violation reverses the polarity of the next input mark. With nothing pending and no strobe, the input rails pass unchanged.
- R7: A pending framing error inverts the bit marked by `frm_pos`. A mark becomes a space, and a space becomes a mark with the polarity opposite to the last mark. The flag then clears.
- R8: A pending CRC error inverts the bit marked by `crc_pos` in the same way as R7, then clears.
- R9: A request that arrives in the same cycle as its position strobe is applied to that bit and leaves nothing pending.
- R10: In T1 mode the polarity of the input marks is ignored. Output marks alternate, and the first mark after reset is positive (`out_pos`).
- R11: `out_pos` and `out_neg` are never high together.
- R12: Reset clears all pending flags.
- R13: A violation is never placed on a bit that a framing or CRC error inverts in that cycle. It waits for a later mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e1 | input | 1 | 0 = T1 AMI, 1 = E1 HDB3 |
| req_lcv | input | 1 | Write-one pulse requesting a line code violation |
| req_frm | input | 1 | Write-one pulse requesting a framing-bit error |
| req_crc | input | 1 | Write-one pulse requesting a CRC-bit error |
| frm_pos | input | 1 | High during a framing bit |
| crc_pos | input | 1 | High during a CRC bit |
| in_pos | input | 1 | Incoming positive rail |
| in_neg | input | 1 | Incoming negative rail |
| out_pos | output | 1 | Outgoing positive rail |
| out_neg | output | 1 | Outgoing negative rail |
| pend_lcv | output | 1 | Violation request still pending |
| pend_frm | output | 1 | Framing error request still pending |
| pend_crc | output | 1 | CRC error request still pending |

## Verification
The assertions assume that the input rails are never both high and that the framing and CRC strobes never fall on the same bit. The E1 pass-through property also assumes that the upstream stream is valid HDB3. The bench drives each bit with at most one rail high and only one strobe at a time, and it changes the mode only while reset is held. Every scenario starts from reset, so the polarity of the first mark is known when it is checked.

// File: rtl/tx_err_inject.sv
module tx_err_inject (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_e1,
  input  logic req_lcv,
  input  logic req_frm,
  input  logic req_crc,
  input  logic frm_pos,
  input  logic crc_pos,
  input  logic in_pos,
  input  logic in_neg,
  output logic out_pos,
  output logic out_neg,
  output logic pend_lcv,
  output logic pend_frm,
  output logic pend_crc
);

  logic last_pos, prev_mark;
  logic arm_l, arm_f, arm_c;
  logic hit_f, hit_c, inv, mark_in, mark_out, lcv_hit, pol;

  assign arm_l   = pend_lcv | req_lcv;
  assign arm_f   = pend_frm | req_frm;
  assign arm_c   = pend_crc | req_crc;
  assign mark_in = in_pos | in_neg;

  assign hit_f    = frm_pos & arm_f;
  assign hit_c    = crc_pos & arm_c;
  assign inv      = hit_f | hit_c;
  assign mark_out = mark_in ^ inv;
  assign lcv_hit  = arm_l & mark_in & ~inv & (mode_e1 | prev_mark);

  always_comb begin
    if (inv)          pol = ~last_pos;
    else if (mode_e1) pol = in_pos ^ lcv_hit;
    else              pol = lcv_hit ? last_pos : ~last_pos;
  end

  assign out_pos = mark_out & pol;
  assign out_neg = mark_out & ~pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_lcv  <= 1'b0;
      pend_frm  <= 1'b0;
      pend_crc  <= 1'b0;
      last_pos  <= 1'b0;
      prev_mark <= 1'b0;
    end else begin
      pend_lcv  <= arm_l & ~lcv_hit;
      pend_frm  <= arm_f & ~hit_f;
      pend_crc  <= arm_c & ~hit_c;
      prev_mark <= mark_out;
      if (mark_out) last_pos <= pol;
    end
  end

  p_rails_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_pos && out_neg));

  p_arm_crc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_crc && !crc_pos |=> pend_crc);

  p_hold_lcv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_lcv && !out_pos && !out_neg |=> pend_lcv);

  p_frm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_frm && frm_pos |=> !pend_frm);

  p_crc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_crc && crc_pos |=> !pend_crc);

  p_e1_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_e1 && !pend_lcv && !req_lcv && !frm_pos && !crc_pos
      |-> (out_pos == in_pos) && (out_neg == in_neg));

  p_reset_clear_r12: assert property (@(posedge clk)
    !rst_n |=> !pend_lcv && !pend_frm && !pend_crc);

endmodule

// File: tb/test_tx_err_inject.sv
`timescale 1ns/1ps
module test_tx_err_inject;
  logic clk = 1'b0, rst_n = 1'b0, mode_e1 = 1'b0;
  logic req_lcv = 0, req_frm = 0, req_crc = 0, frm_pos = 0, crc_pos = 0;
  logic in_pos = 0, in_neg = 0;
  logic out_pos, out_neg, pend_lcv, pend_frm, pend_crc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_err_inject i_tx_err_inject (.*);

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic e1);
    @(negedge clk);
    rst_n = 0; mode_e1 = e1;
    {req_lcv, req_frm, req_crc, frm_pos, crc_pos, in_pos, in_neg} = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input logic p, input logic n, input logic fp, input logic cp,
                      input logic rl, input logic rf, input logic rc,
                      input logic ep, input logic en, input string req);
    @(negedge clk);
    in_pos = p; in_neg = n; frm_pos = fp; crc_pos = cp;
    req_lcv = rl; req_frm = rf; req_crc = rc;
    #1;
    check(req, {1'b0, out_pos, out_neg}, {1'b0, ep, en});
    if (out_pos && out_neg) check("R11", {2'b0, 1'b1}, 3'b0);
  endtask

  task automatic pend(input logic el, input logic ef, input logic ec, input string req);
    @(posedge clk); #1;
    check(req, {pend_lcv, pend_frm, pend_crc}, {el, ef, ec});
  endtask

  task automatic t_reset;
    do_reset(0);
    @(negedge clk);
    check("R12", {pend_lcv, pend_frm, pend_crc}, 3'b000);
  endtask

  task automatic t_t1_alt;
    do_reset(0);
    step(1,0,0,0,0,0,0, 1,0, "R10");
    step(1,0,0,0,0,0,0, 0,1, "R10");
    step(0,0,0,0,0,0,0, 0,0, "R10");
    step(0,1,0,0,0,0,0, 1,0, "R10");
  endtask

  task automatic t_t1_lcv;
    do_reset(0);
    step(0,0,0,0,1,0,0, 0,0, "R1");
    pend(1,0,0, "R1");
    step(1,0,0,0,0,0,0, 1,0, "R5");
    pend(1,0,0, "R4");
    step(1,0,0,0,0,0,0, 1,0, "R5");
    pend(0,0,0, "R4");
    step(1,0,0,0,0,0,0, 0,1, "R5");
  endtask

  task automatic t_e1_lcv;
    do_reset(1);
    step(1,0,0,0,0,0,0, 1,0, "R6");
    step(0,0,0,0,1,0,0, 0,0, "R6");
    step(0,1,0,0,0,0,0, 1,0, "R6");
    pend(0,0,0, "R6");
    step(1,0,0,0,0,0,0, 1,0, "R6");
    step(0,1,0,0,0,0,0, 0,1, "R6");
  endtask

  task automatic t_frame;
    do_reset(0);
    step(1,0,0,0,0,1,0, 1,0, "R7");
    pend(0,1,0, "R1");
    step(0,0,0,0,0,0,0, 0,0, "R2");
    pend(0,1,0, "R2");
    step(1,0,1,0,0,0,0, 0,0, "R7");
    pend(0,0,0, "R7");
    step(1,0,1,0,0,0,0, 0,1, "R2");
    step(0,0,1,0,0,1,0, 1,0, "R9");
    pend(0,0,0, "R9");
  endtask

  task automatic t_crc;
    do_reset(1);
    step(0,1,0,0,0,0,0, 0,1, "R6");
    step(0,0,0,0,0,0,1, 0,0, "R8");
    pend(0,0,1, "R8");
    step(0,0,0,1,0,0,0, 1,0, "R8");
    pend(0,0,0, "R8");
  endtask

  task automatic t_multi;
    do_reset(0);
    step(0,0,0,0,1,1,1, 0,0, "R3");
    pend(1,1,1, "R3");
    step(1,0,1,0,0,0,0, 0,0, "R13");
    pend(1,0,1, "R13");
    step(1,0,0,0,0,0,0, 1,0, "R5");
    step(1,0,0,1,0,0,0, 0,0, "R8");
    pend(1,0,0, "R3");
    step(1,0,0,0,0,0,0, 0,1, "R10");
    step(1,0,0,0,0,0,0, 0,1, "R5");
    pend(0,0,0, "R4");
  endtask

  initial begin
    t_reset;
    t_t1_alt;
    t_t1_lcv;
    t_e1_lcv;
    t_frame;
    t_crc;
    t_multi;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule